// File: doc/BRIEF.md
# Dependency-Ordered Rail Sequencer

This block controls the enable pins of a small group of power rails. Each rail carries a dependency set, written as one row of a square bit matrix. A rail begins its turn-on countdown only when every rail in its set is qualified. A rail is qualified once its power-good input has stayed high for a minimum hold time. All timing counts pulses of a one-millisecond strobe. The same counters therefore serve any system clock.

Raising the power request starts a power-up. The request is refused when the matrix holds a loop. The cold/warm select adds a cold-only extra delay to every turn-on countdown. A rail whose power-good does not arrive in time causes a pg-timeout fault, and the fault names the rail. The block then drops all enables, waits a cool-down and tries again. When the retries are used up it shuts down for good. A qualified rail that loses power-good is a brown-out. The block drops every enable, waits a blanking period and then starts the power-up again. Dropping the request turns the rails off in reverse dependency order, with a turn-off delay on each rail.

Top module: `psq_seq`

## Requirements
- R1: Bit `i*NR+j` of `dep_mask` set means rail i depends on rail j. Rail i's enable rises exactly `ton` ticks after the later of two events: the start tick, or the tick at which the last rail in its set became qualified.
- R2: `ton` is `TON` when `cold_boot` is low and `TON+COLD_EXTRA` when it is high. For a rail with no dependencies, the enable rises `ton` ticks after the start tick.
- R3: A rail becomes qualified on the `HOLD`-th tick after power-good was first seen high with the rail enabled. Power-good must stay high for that whole time.
- R4: After `pwr_req` falls, a rail's enable falls `TOFF` ticks after the later of two events: the stop tick, or the tick at which the last rail depending on it switched off. When every enable is low, the phase returns to idle.
- R5: When an enabled rail goes `PG_TMO` ticks without power-good during power-up, the block reports `fault_kind` = 1 with that rail's index on `fault_rail`. It reports this on the timeout tick.
- R6: After a pg-timeout, all enables drop and the cool-down phase lasts `COOL` ticks before power-up begins again. The timeout that follows `MAX_RETRY` retries moves the block to the shutdown phase instead. That phase holds every enable low until `pwr_req` falls.
- R7: A qualified rail losing power-good sets `fault_kind` = 2 with that rail's index. The block enters the blanking phase and drops all enables. Power-up restarts `BLANK` ticks after the loss.
- R8: A start request with a dependency loop, a self-dependency included, enters the config-error phase. In that phase `cfg_err` = 1, `fault_kind` = 3 and no enable asserts.
- R9: `phase` is one-hot with these bits: 0 idle, 1 power-up, 2 running, 3 power-down, 4 cool-down, 5 blanking, 6 shutdown, 7 config-error. `seq_done` is high exactly in the running phase, which is entered once every rail is qualified.
- R10: After reset all enables are low, the phase is idle, `seq_done` and `cfg_err` are 0, and `fault_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| pwr_req | input | 1 | High requests power-up, low requests power-down |
| cold_boot | input | 1 | High selects the cold turn-on delays |
| dep_mask | input | NR*NR | Dependency matrix, row i = rails that rail i waits for |
| pg_in | input | NR | Per-rail power-good |
| rail_en | output | NR | Per-rail enable |
| fault_kind | output | 2 | 0 none, 1 pg timeout, 2 pg loss, 3 config |
| fault_rail | output | $clog2(NR) | Rail named by the last fault |
| cfg_err | output | 1 | Dependency loop rejected |
| phase | output | 8 | One-hot sequencing phase |
| seq_done | output | 1 | All rails up and qualified |

## Verification
A wrong count in a rail's on, off, hold or timeout timer shows up directly as an enable edge that lands on the wrong millisecond tick. The bench measures every edge against a tick figure computed from the matrix, so such an error is caught within one rail transition. A corrupt dependency decode, a wrong loop detection or a wrong retry counter either releases a rail ahead of its set or leaves the phase output on the wrong bit. Either one is visible at the ports in the same sequence where it happens.

// File: rtl/psq_pkg.sv
`timescale 1ns/1ps
package psq_pkg;
   localparam int PSQ_NPH = 8;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_UP    = 3'd1,
      PH_RUN   = 3'd2,
      PH_DOWN  = 3'd3,
      PH_COOL  = 3'd4,
      PH_BLANK = 3'd5,
      PH_SHUT  = 3'd6,
      PH_CFG   = 3'd7
   } psq_phase_e;

   typedef enum logic [1:0] {
      FK_NONE    = 2'd0,
      FK_TIMEOUT = 2'd1,
      FK_PGLOSS  = 2'd2,
      FK_CONFIG  = 2'd3
   } psq_fault_e;

   typedef enum logic [2:0] {
      RS_OFF     = 3'd0,
      RS_DLY_ON  = 3'd1,
      RS_WAIT_PG = 3'd2,
      RS_HOLD    = 3'd3,
      RS_UP      = 3'd4,
      RS_DLY_OFF = 3'd5
   } psq_rail_e;
endpackage

// File: rtl/psq_loop_det.sv
`timescale 1ns/1ps
// Transitive closure of the dependency matrix; flags any rail that reaches itself.
module psq_loop_det #(
   parameter int NR = 8
) (
   input  logic [NR*NR-1:0] dep_mask,
   output logic             loop_found
);
   logic [NR-1:0] reach [NR];

   always_comb begin
      for (int i = 0; i < NR; i++) reach[i] = dep_mask[i*NR +: NR];
      for (int k = 0; k < NR; k++)
         for (int i = 0; i < NR; i++)
            for (int j = 0; j < NR; j++)
               if (reach[i][j]) reach[i] = reach[i] | reach[j];
      loop_found = 1'b0;
      for (int i = 0; i < NR; i++) loop_found = loop_found | reach[i][i];
   end
endmodule

// File: rtl/psq_rail.sv
`timescale 1ns/1ps
// One rail slot: on-delay, power-good wait with timeout, hold qualification, off-delay.
module psq_rail
   import psq_pkg::*;
#(
   parameter int CW         = 5,
   parameter int TON        = 5,
   parameter int TOFF       = 5,
   parameter int COLD_EXTRA = 2,
   parameter int HOLD       = 3,
   parameter int PG_TMO     = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cold,
   input  logic pg,
   input  logic go_up,
   input  logic go_down,
   input  logic kill,
   output logic en,
   output logic qual,
   output logic is_off,
   output logic tmo,
   output logic lost
);
   localparam logic [CW-1:0] ONE      = CW'(1);
   localparam logic [CW-1:0] LIM_WARM = CW'(TON);
   localparam logic [CW-1:0] LIM_COLD = CW'(TON + COLD_EXTRA);
   localparam logic [CW-1:0] HOLD_END = CW'(HOLD - 1);
   localparam logic [CW-1:0] TMO_END  = CW'(PG_TMO - 1);
   localparam logic [CW-1:0] OFF_END  = CW'(TOFF - 1);

   psq_rail_e     st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= RS_OFF;
         cnt <= '0;
         lim <= LIM_WARM;
      end else if (kill) begin
         st  <= RS_OFF;
         cnt <= '0;
      end else begin
         case (st)
            RS_OFF: if (go_up) begin
               st  <= RS_DLY_ON;
               cnt <= '0;
               lim <= cold ? LIM_COLD : LIM_WARM;
            end
            RS_DLY_ON: begin
               if (go_down) st <= RS_OFF;
               else if (tick) begin
                  if (cnt == lim - ONE) begin
                     st  <= RS_WAIT_PG;
                     cnt <= '0;
                  end else cnt <= cnt + ONE;
               end
            end
            RS_WAIT_PG: begin
               if (go_down) begin
                  st  <= RS_DLY_OFF;
                  cnt <= '0;
               end else if (pg) begin
                  st  <= RS_HOLD;
                  cnt <= '0;
               end else if (tick && cnt != TMO_END) cnt <= cnt + ONE;
            end
            RS_HOLD: begin
               if (go_down) begin
                  st  <= RS_DLY_OFF;
                  cnt <= '0;
               end else if (!pg) begin
                  st  <= RS_WAIT_PG;
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt == HOLD_END) st <= RS_UP;
                  else cnt <= cnt + ONE;
               end
            end
            RS_UP: if (go_down) begin
               st  <= RS_DLY_OFF;
               cnt <= '0;
            end
            RS_DLY_OFF: if (tick) begin
               if (cnt == OFF_END) st <= RS_OFF;
               else cnt <= cnt + ONE;
            end
            default: st <= RS_OFF;
         endcase
      end
   end

   assign en     = (st == RS_WAIT_PG) || (st == RS_HOLD) || (st == RS_UP) || (st == RS_DLY_OFF);
   assign qual   = (st == RS_UP);
   assign is_off = (st == RS_OFF);
   assign tmo    = (st == RS_WAIT_PG) && tick && !pg && (cnt == TMO_END);
   assign lost   = (st == RS_UP) && !pg;

   // R2
   en_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> $past(tick));
   // R3
   qual_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(pg));
   // R6
   kill_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !en);
endmodule

// File: rtl/psq_seq.sv
`timescale 1ns/1ps
// Top: phase controller, dependency gating, retry and blanking timers.
module psq_seq
   import psq_pkg::*;
#(
   parameter int NR         = 8,
   parameter int TON        = 5,
   parameter int TOFF       = 5,
   parameter int COLD_EXTRA = 2,
   parameter int HOLD       = 3,
   parameter int PG_TMO     = 20,
   parameter int COOL       = 10,
   parameter int BLANK      = 8,
   parameter int MAX_RETRY  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ms_tick,
   input  logic                  pwr_req,
   input  logic                  cold_boot,
   input  logic [NR*NR-1:0]      dep_mask,
   input  logic [NR-1:0]         pg_in,
   output logic [NR-1:0]         rail_en,
   output logic [1:0]            fault_kind,
   output logic [$clog2(NR)-1:0] fault_rail,
   output logic                  cfg_err,
   output logic [PSQ_NPH-1:0]    phase,
   output logic                  seq_done
);
   localparam int IW    = $clog2(NR);
   localparam int M1    = (TON + COLD_EXTRA > TOFF) ? TON + COLD_EXTRA : TOFF;
   localparam int M2    = (HOLD > PG_TMO) ? HOLD : PG_TMO;
   localparam int RMAX  = (M1 > M2) ? M1 : M2;
   localparam int CW    = $clog2(RMAX + 1);
   localparam int TMAX  = (COOL > BLANK) ? COOL : BLANK;
   localparam int TW    = $clog2(TMAX + 1);
   localparam int RW    = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
   localparam logic [TW-1:0] COOL_END  = TW'(COOL - 1);
   localparam logic [TW-1:0] BLANK_END = TW'(BLANK - 1);
   localparam logic [RW-1:0] TRY_LAST  = RW'(MAX_RETRY);

   initial begin : param_range_chk
      assert (NR >= 2) else $fatal(1, "NR must be at least 2");
      assert (TON >= 1 && TOFF >= 1 && HOLD >= 1 && PG_TMO >= 1) else $fatal(1, "rail delays must be at least 1");
      assert (COOL >= 1 && BLANK >= 1 && COLD_EXTRA >= 0 && MAX_RETRY >= 0) else $fatal(1, "bad timer setting");
   end

   psq_phase_e    ph;
   psq_fault_e    fk;
   logic [IW-1:0] fr;
   logic [TW-1:0] tmr;
   logic [RW-1:0] tries;
   logic          loop_found;
   logic          kill;
   logic [NR-1:0] qual_w, off_w, tmo_w, lost_w, go_up, go_down;

   function automatic logic [IW-1:0] first_set(input logic [NR-1:0] v);
      logic [IW-1:0] r;
      r = '0;
      for (int k = NR - 1; k >= 0; k--) if (v[k]) r = IW'(k);
      return r;
   endfunction

   psq_loop_det #(.NR(NR)) u_loop (.dep_mask(dep_mask), .loop_found(loop_found));

   assign kill = !(ph inside {PH_UP, PH_RUN, PH_DOWN});

   for (genvar i = 0; i < NR; i++) begin : g_rail
      logic [NR-1:0] row;
      logic [NR-1:0] col;
      assign row = dep_mask[i*NR +: NR];
      always_comb begin
         for (int j = 0; j < NR; j++) col[j] = dep_mask[j*NR + i];
      end
      assign go_up[i]   = (ph == PH_UP) && (&(qual_w | ~row));
      assign go_down[i] = (ph == PH_DOWN) && (&(off_w | ~col));

      psq_rail #(.CW(CW), .TON(TON), .TOFF(TOFF), .COLD_EXTRA(COLD_EXTRA),
                 .HOLD(HOLD), .PG_TMO(PG_TMO)) u_rail (
         .clk(clk), .rst_n(rst_n), .tick(ms_tick), .cold(cold_boot), .pg(pg_in[i]),
         .go_up(go_up[i]), .go_down(go_down[i]), .kill(kill),
         .en(rail_en[i]), .qual(qual_w[i]), .is_off(off_w[i]),
         .tmo(tmo_w[i]), .lost(lost_w[i]));

      // R1
      rel_after_deps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rail_en[i]) |-> &(qual_w | ~row));
      // R4
      down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(rail_en[i]) && ph == PH_DOWN) |-> &(off_w | ~col));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         fk    <= FK_NONE;
         fr    <= '0;
         tmr   <= '0;
         tries <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (pwr_req) begin
               fr <= '0;
               if (loop_found) begin
                  ph <= PH_CFG;
                  fk <= FK_CONFIG;
               end else begin
                  ph    <= PH_UP;
                  fk    <= FK_NONE;
                  tries <= '0;
               end
            end
            PH_UP, PH_RUN: begin
               if (ph == PH_UP && |tmo_w) begin
                  fk  <= FK_TIMEOUT;
                  fr  <= first_set(tmo_w);
                  tmr <= '0;
                  if (tries == TRY_LAST) ph <= PH_SHUT;
                  else begin
                     ph    <= PH_COOL;
                     tries <= tries + RW'(1);
                  end
               end else if (|lost_w) begin
                  fk  <= FK_PGLOSS;
                  fr  <= first_set(lost_w);
                  tmr <= '0;
                  ph  <= PH_BLANK;
               end else if (!pwr_req) ph <= PH_DOWN;
               else if (ph == PH_UP && &qual_w) ph <= PH_RUN;
            end
            PH_DOWN: if (&off_w) ph <= PH_IDLE;
            PH_COOL, PH_BLANK: if (ms_tick) begin
               if (tmr == ((ph == PH_COOL) ? COOL_END : BLANK_END)) begin
                  tmr <= '0;
                  ph  <= pwr_req ? PH_UP : PH_IDLE;
               end else tmr <= tmr + TW'(1);
            end
            PH_SHUT, PH_CFG: if (!pwr_req) ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign phase      = PSQ_NPH'(1) << ph;
   assign seq_done   = (ph == PH_RUN);
   assign cfg_err    = (ph == PH_CFG);
   assign fault_kind = fk;
   assign fault_rail = fr;

   // R9
   done_all_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> &qual_w);
   // R8
   cfg_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> rail_en == '0);
   // R6
   shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph == PH_SHUT) && ph == PH_SHUT) |-> rail_en == '0);
   // R7
   blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph == PH_BLANK) && ph == PH_BLANK) |-> rail_en == '0);
endmodule

// File: tb/sim_psq_seq.sv
`timescale 1ns/1ps
module sim_psq_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4, TON = 3, TOFF = 2, CX = 2, HOLD = 3, TMO = 6;
   localparam int COOL = 4, BLANK = 5, MAXR = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic        pwr_req = 1'b0;
   logic        cold = 1'b0;
   logic [15:0] dep = '0;
   logic [3:0]  pg = '0;
   logic [3:0]  en;
   logic [1:0]  fault_kind;
   logic [1:0]  fault_rail;
   logic        cfg_err;
   logic [7:0]  phase;
   logic        seq_done;

   int checks = 0, errors = 0, cyc = 0, tick_cnt = 0, div = 0;
   int t_en[4], t_off[4], pgl[4];
   bit prev_en[4], force_lo[4];

   psq_seq #(.NR(NR), .TON(TON), .TOFF(TOFF), .COLD_EXTRA(CX), .HOLD(HOLD),
             .PG_TMO(TMO), .COOL(COOL), .BLANK(BLANK), .MAX_RETRY(MAXR)) u0 (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_req(pwr_req), .cold_boot(cold),
      .dep_mask(dep), .pg_in(pg), .rail_en(en), .fault_kind(fault_kind),
      .fault_rail(fault_rail), .cfg_err(cfg_err), .phase(phase), .seq_done(seq_done));

   always #(CLK_PERIOD/2) clk = ~clk;

   // Edge monitor, power-good model and millisecond strobe, all on the falling edge.
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (en[i] && !prev_en[i]) t_en[i] = tick_cnt;
         if (!en[i] && prev_en[i]) t_off[i] = tick_cnt;
         prev_en[i] = en[i];
         pg[i] = en[i] && !force_lo[i] && (tick_cnt - t_en[i] >= pgl[i]);
      end
      div = (div == 3) ? 0 : div + 1;
      ms_tick = (div == 0);
      if (ms_tick) tick_cnt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog (all requirements) act=%0d exp<=%0d", cyc, 190000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic sync_tick();
      do step(); while (!ms_tick);
   endtask

   task automatic wait_phase(input string req, input logic [7:0] v);
      int n = 0;
      while (phase != v && n < 4000) begin step(); n++; end
      chk(req, int'(phase), int'(v));
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) sync_tick();
   endtask

   task automatic run_cfg(input logic [15:0] dm, input bit cb);
      int s, d, ton, m;
      int te[4], tq[4], td[4];
      sync_tick();
      s = tick_cnt; dep = dm; cold = cb; pwr_req = 1'b1;
      wait_phase("R9", 8'h04);
      chk("R9", int'(seq_done), 1);
      ton = TON + (cb ? CX : 0);
      for (int i = 0; i < 4; i++) tq[i] = 0;
      for (int p = 0; p < 4; p++)
         for (int i = 0; i < 4; i++) begin
            m = s;
            for (int j = 0; j < 4; j++) if (dm[i*4+j] && tq[j] > m) m = tq[j];
            te[i] = m + ton;
            tq[i] = te[i] + pgl[i] + HOLD;
         end
      for (int i = 0; i < 4; i++)
         chk((dm[i*4 +: 4] != 0) ? "R1 R3" : "R2", t_en[i], te[i]);
      sync_tick();
      d = tick_cnt; pwr_req = 1'b0;
      wait_phase("R4", 8'h01);
      chk("R9", int'(seq_done), 0);
      for (int i = 0; i < 4; i++) td[i] = 0;
      for (int p = 0; p < 4; p++)
         for (int i = 0; i < 4; i++) begin
            m = d;
            for (int j = 0; j < 4; j++) if (dm[j*4+i] && td[j] > m) m = td[j];
            td[i] = m + TOFF;
         end
      for (int i = 0; i < 4; i++) chk("R4", t_off[i], td[i]);
   endtask

   initial begin
      int s, k;
      logic [15:0] dm;
      for (int i = 0; i < 4; i++) begin
         t_en[i] = 0; t_off[i] = 0; prev_en[i] = 0; force_lo[i] = 0;
      end
      pgl[0] = 0; pgl[1] = 2; pgl[2] = 0; pgl[3] = 1;
      repeat (5) step();
      rst_n = 1'b1;
      step();
      // R10 reset state
      chk("R10", int'(en), 0);
      chk("R10", int'(phase), 1);
      chk("R10", int'(seq_done), 0);
      chk("R10", int'(cfg_err), 0);
      chk("R10", int'(fault_kind), 0);

      // Sweep: every downward-edge matrix, mirrored, cold and warm.
      for (int rev = 0; rev < 2; rev++)
         for (int mm = 0; mm < 64; mm++)
            for (int c = 0; c < 2; c++) begin
               dm = '0; k = 0;
               for (int i = 1; i < 4; i++)
                  for (int j = 0; j < i; j++) begin
                     if (mm[k]) begin
                        if (rev == 1) dm[(3-i)*4 + (3-j)] = 1'b1;
                        else dm[i*4 + j] = 1'b1;
                     end
                     k++;
                  end
               run_cfg(dm, c[0]);
            end

      // R8 loop rejection: self loop, two-cycle, three-cycle.
      for (int t = 0; t < 3; t++) begin
         dm = '0;
         if (t == 0) dm[2*4+2] = 1'b1;
         if (t == 1) begin dm[0*4+3] = 1'b1; dm[3*4+0] = 1'b1; end
         if (t == 2) begin dm[1*4+2] = 1'b1; dm[2*4+3] = 1'b1; dm[3*4+1] = 1'b1; dm[0*4+1] = 1'b1; end
         dep = dm; pwr_req = 1'b1;
         wait_ticks(3);
         chk("R8", int'(cfg_err), 1);
         chk("R8", int'(phase), 8'h80);
         chk("R8", int'(fault_kind), 3);
         chk("R8", int'(en), 0);
         pwr_req = 1'b0;
         wait_phase("R8", 8'h01);
      end

      // R5 / R6: rail 2 never reports power-good.
      pgl[2] = 100000;
      dep = 16'h0000; cold = 1'b0;
      sync_tick();
      s = tick_cnt; pwr_req = 1'b1;
      for (int a = 0; a <= MAXR; a++) begin
         wait_phase("R6", 8'h02);
         while (phase == 8'h02) step();
         chk("R2", t_en[2], s + TON);
         chk("R5", tick_cnt, s + TON + TMO);
         chk("R5", int'(fault_kind), 1);
         chk("R5", int'(fault_rail), 2);
         k = tick_cnt;
         if (a < MAXR) begin
            chk("R6", int'(phase), 8'h10);
            step(); step();
            chk("R6", int'(en), 0);
            wait_phase("R6", 8'h02);
            chk("R6", tick_cnt, k + COOL);
            s = k + COOL;
         end else begin
            chk("R6", int'(phase), 8'h40);
         end
      end
      wait_ticks(12);
      chk("R6", int'(phase), 8'h40);
      chk("R6", int'(en), 0);
      pwr_req = 1'b0;
      wait_phase("R6", 8'h01);
      pgl[2] = 0;

      // R7 brown-out: rail 1 depends on rail 0, rail 1 drops power-good while running.
      dep = 16'h0000; dep[1*4+0] = 1'b1;
      sync_tick();
      pwr_req = 1'b1;
      wait_phase("R9", 8'h04);
      sync_tick();
      k = tick_cnt; force_lo[1] = 1;
      step();
      chk("R7", int'(phase), 8'h20);
      chk("R7", int'(fault_kind), 2);
      chk("R7", int'(fault_rail), 1);
      force_lo[1] = 0;
      step();
      chk("R7", int'(en), 0);
      wait_phase("R7", 8'h02);
      chk("R7", tick_cnt, k + BLANK);
      wait_phase("R7", 8'h04);
      s = k + BLANK;
      chk("R7", t_en[0], s + TON);
      chk("R7", t_en[1], s + TON + pgl[0] + HOLD + TON);
      pwr_req = 1'b0;
      wait_phase("R4", 8'h01);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule